// File: doc/BRIEF.md
# PCIe Root-Port Power and Reset Bring-Up Sequencer

This block walks a PCIe root-complex subsystem from cold reset to a configured, ready state, one output change at a time. On a start request it first makes sure both fundamental resets are asserted: the board-level slot reset pin and the reset bit inside the controller. It then turns on slot power and waits out a settling interval measured in milliseconds. The wait is timed from a clock-frequency parameter. After the wait it releases the two resets in the reverse order.

Once the link partner is out of reset, the sequencer opens a window for programming the PHY. It enables the auxiliary clock, holds the PHY in reset and releases the subsystem's power-up reset. It then hands control to an external PHY-programming engine through a one-cycle kick and waits for that engine's completion strobe. To close the window it gates the auxiliary clock off, drops the PHY hold, turns the clock back on and writes the root-complex code into the device-type field.

A shutdown request puts both resets back into assertion, so that a later boot finds the link in a clean state. Shutdown works from any point, including in the middle of a bring-up. Start requests that arrive while a sequence is running are dropped.

Top module: `pcie_bringup_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, every output is 0: both resets asserted, power, clock and PHY hold off, power-up reset held, device type 0, and `busy_o`, `done_o` and `phy_init_start_o` low.
- R2: An accepted start drives `perst_pin_n_o` to 0 one cycle before `ctrl_perst_n_o` is driven to 0.
- R3: `slot_pwr_en_o` rises only while both resets read 0, exactly three cycles after `busy_o` rises on a start from idle.
- R4: `ctrl_perst_n_o` returns to 1 no sooner than WAIT_MS × (CLK_HZ/1000) cycles after slot power is on with the controller reset asserted, and within 9 cycles beyond that.
- R5: `perst_pin_n_o` returns to 1 exactly one cycle after `ctrl_perst_n_o` does.
- R6: After the pin reset is released, `aux_clk_en_o`, `hold_phy_rst_o` and `pwrup_rst_n_o` go to 1 in that order, one step per cycle.
- R7: `phy_init_start_o` is a single-cycle pulse in the same cycle `pwrup_rst_n_o` first reads 1, always with `hold_phy_rst_o` at 1, and the sequence waits there until `phy_init_done_i`.
- R8: After `phy_init_done_i`, on successive cycles the aux clock goes to 0, the hold goes to 0, the aux clock goes back to 1, and then `dev_type_o` becomes 4 in the same cycle that `busy_o` falls and `done_o` rises.
- R9: `start_i` has no effect while `busy_o` is 1; in particular, it does not restart the power-settling wait.
- R10: A shutdown while ready raises `busy_o` and drops `done_o`, drives `perst_pin_n_o` to 0 one cycle later and `ctrl_perst_n_o` to 0 the cycle after that (with `busy_o` falling then), and leaves power, clock, hold, power-up reset and device type unchanged.
- R11: `shutdown_i` takes priority over `start_i` in the same cycle and aborts a running bring-up; no reset is released afterwards until a new start.
- R12: `busy_o` and `done_o` are never both 1; `busy_o` rises in the cycle after an accepted start, and a start from the ready state clears `done_o` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a bring-up (ignored while busy) |
| shutdown_i | input | 1 | Request that both link resets be asserted |
| phy_init_done_i | input | 1 | Completion strobe from the PHY-programming engine |
| perst_pin_n_o | output | 1 | Board slot reset pin, 0 = asserted |
| ctrl_perst_n_o | output | 1 | Controller-side reset bit, 0 = asserted |
| slot_pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock enable |
| hold_phy_rst_o | output | 1 | Hold the PHY and link state machine in reset |
| pwrup_rst_n_o | output | 1 | Subsystem power-up reset, 0 = held |
| dev_type_o | output | DEV_TYPE_W | Device-type field, 4 = root complex |
| phy_init_start_o | output | 1 | One-cycle kick to the PHY-programming engine |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Bring-up complete, subsystem ready |

## Verification
The sequencer has no data path, so a wrong internal state can only show up as an output step that comes too early, too late, in the wrong order or not at all. Each output change is therefore compared as a whole output snapshot, together with the number of cycles since the previous change. A skipped, repeated or reordered state shows as a mismatch at the very next change, within one cycle. A wrong timer count shows at the controller reset release, about 100 ms of cycles after power-on. A shutdown or a blocked start that loses its priority is caught during a quiet window longer than the settling wait, in which any output change is an error.

// File: rtl/pbs_pkg.sv
// Shared state encoding for the bring-up sequencer.
// Assumes: each state performs at most one output step.
package pbs_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PIN_ASSERT,
        ST_CTRL_ASSERT,
        ST_PWR_ON,
        ST_PWR_WAIT,
        ST_CTRL_RELEASE,
        ST_PIN_RELEASE,
        ST_AUX_ON,
        ST_HOLD_SET,
        ST_PWRUP_RELEASE,
        ST_PHY_KICK,
        ST_PHY_WAIT,
        ST_AUX_OFF,
        ST_HOLD_CLEAR,
        ST_AUX_RESTORE,
        ST_DEVTYPE,
        ST_READY,
        ST_SD_PIN,
        ST_SD_CTRL
    } pbs_state_e;

    // True for every state in which a sequence is in flight.
    function automatic logic pbs_is_busy(pbs_state_e s);
        return (s != ST_IDLE) && (s != ST_READY);
    endfunction

endpackage

// File: rtl/pbs_ms_timer.sv
// Millisecond settling timer.
// Derives a 1 ms tick from CLK_HZ and counts WAIT_MS ticks after start_i.
// Assumes: CLK_HZ >= 1000 (smaller values round to one cycle per tick) and WAIT_MS >= 1.
// expired_o stays high from expiry until the next start_i.
module pbs_ms_timer #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned WAIT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int unsigned TICKS_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int unsigned PRE_W        = $clog2(TICKS_PER_MS + 1);
    localparam int unsigned MS_W         = $clog2(WAIT_MS + 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [MS_W-1:0]  ms_cnt;
    logic             running;
    logic             expired;

    // Prescaler and millisecond counter; restarts on every start_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            ms_cnt  <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else if (start_i) begin
            pre_cnt <= '0;
            ms_cnt  <= '0;
            running <= 1'b1;
            expired <= 1'b0;
        end else if (running) begin
            if (pre_cnt == PRE_W'(TICKS_PER_MS - 1)) begin
                pre_cnt <= '0;
                ms_cnt  <= ms_cnt + 1'b1;
                if (ms_cnt == MS_W'(WAIT_MS - 1)) begin
                    running <= 1'b0;
                    expired <= 1'b1;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign expired_o = expired;

endmodule

// File: rtl/pbs_step_fsm.sv
// Step sequencer: walks the bring-up and shutdown orderings.
// Assumes: shutdown_i has priority over everything; start_i is honoured
// only in ST_IDLE or ST_READY.
module pbs_step_fsm
    import pbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       shutdown_i,
    input  logic       wait_done_i,
    input  logic       phy_done_i,
    output pbs_state_e state_o
);
    pbs_state_e state_q;
    pbs_state_e state_d;

    // Next-state selection, one output step per state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_READY: if (start_i) state_d = ST_PIN_ASSERT;
            ST_PIN_ASSERT:     state_d = ST_CTRL_ASSERT;
            ST_CTRL_ASSERT:    state_d = ST_PWR_ON;
            ST_PWR_ON:         state_d = ST_PWR_WAIT;
            ST_PWR_WAIT:       if (wait_done_i) state_d = ST_CTRL_RELEASE;
            ST_CTRL_RELEASE:   state_d = ST_PIN_RELEASE;
            ST_PIN_RELEASE:    state_d = ST_AUX_ON;
            ST_AUX_ON:         state_d = ST_HOLD_SET;
            ST_HOLD_SET:       state_d = ST_PWRUP_RELEASE;
            ST_PWRUP_RELEASE:  state_d = ST_PHY_KICK;
            ST_PHY_KICK:       state_d = ST_PHY_WAIT;
            ST_PHY_WAIT:       if (phy_done_i) state_d = ST_AUX_OFF;
            ST_AUX_OFF:        state_d = ST_HOLD_CLEAR;
            ST_HOLD_CLEAR:     state_d = ST_AUX_RESTORE;
            ST_AUX_RESTORE:    state_d = ST_DEVTYPE;
            ST_DEVTYPE:        state_d = ST_READY;
            ST_SD_PIN:         state_d = ST_SD_CTRL;
            ST_SD_CTRL:        state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
        if (shutdown_i && (state_q != ST_SD_PIN) && (state_q != ST_SD_CTRL))
            state_d = ST_SD_PIN;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/pbs_out_regs.sv
// Output register bank: applies the single action owned by the current
// state, so every output change lands on the edge that leaves that state.
// Assumes: reset values are the safe, fully-held state.
module pbs_out_regs
    import pbs_pkg::*;
#(
    parameter int unsigned DEV_TYPE_W  = 4,
    parameter int unsigned DEV_TYPE_RC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pbs_state_e            state_i,
    output logic                  perst_pin_n_o,
    output logic                  ctrl_perst_n_o,
    output logic                  slot_pwr_en_o,
    output logic                  aux_clk_en_o,
    output logic                  hold_phy_rst_o,
    output logic                  pwrup_rst_n_o,
    output logic [DEV_TYPE_W-1:0] dev_type_o,
    output logic                  phy_kick_o,
    output logic                  busy_o,
    output logic                  done_o
);
    // Per-state output action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perst_pin_n_o  <= 1'b0;
            ctrl_perst_n_o <= 1'b0;
            slot_pwr_en_o  <= 1'b0;
            aux_clk_en_o   <= 1'b0;
            hold_phy_rst_o <= 1'b0;
            pwrup_rst_n_o  <= 1'b0;
            dev_type_o     <= '0;
        end else begin
            unique case (state_i)
                ST_PIN_ASSERT, ST_SD_PIN:   perst_pin_n_o  <= 1'b0;
                ST_CTRL_ASSERT, ST_SD_CTRL: ctrl_perst_n_o <= 1'b0;
                ST_PWR_ON:                  slot_pwr_en_o  <= 1'b1;
                ST_CTRL_RELEASE:            ctrl_perst_n_o <= 1'b1;
                ST_PIN_RELEASE:             perst_pin_n_o  <= 1'b1;
                ST_AUX_ON, ST_AUX_RESTORE:  aux_clk_en_o   <= 1'b1;
                ST_HOLD_SET:                hold_phy_rst_o <= 1'b1;
                ST_PWRUP_RELEASE:           pwrup_rst_n_o  <= 1'b1;
                ST_AUX_OFF:                 aux_clk_en_o   <= 1'b0;
                ST_HOLD_CLEAR:              hold_phy_rst_o <= 1'b0;
                ST_DEVTYPE:                 dev_type_o     <= DEV_TYPE_W'(DEV_TYPE_RC);
                default: ;
            endcase
        end
    end

    // Status decoded straight from the state register.
    assign phy_kick_o = (state_i == ST_PHY_KICK);
    assign busy_o     = pbs_is_busy(state_i);
    assign done_o     = (state_i == ST_READY);

endmodule

// File: rtl/pcie_bringup_seq.sv
// PCIe root-port power and reset bring-up sequencer (top).
// Joins the step FSM, the settling timer and the output register bank.
// Assumes: phy_init_done_i is a strobe or level from the PHY-programming
// engine, sampled only while waiting for it.
module pcie_bringup_seq
    import pbs_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned WAIT_MS     = 100,
    parameter int unsigned DEV_TYPE_W  = 4,
    parameter int unsigned DEV_TYPE_RC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  shutdown_i,
    input  logic                  phy_init_done_i,
    output logic                  perst_pin_n_o,
    output logic                  ctrl_perst_n_o,
    output logic                  slot_pwr_en_o,
    output logic                  aux_clk_en_o,
    output logic                  hold_phy_rst_o,
    output logic                  pwrup_rst_n_o,
    output logic [DEV_TYPE_W-1:0] dev_type_o,
    output logic                  phy_init_start_o,
    output logic                  busy_o,
    output logic                  done_o
);
    localparam int unsigned TICKS_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int unsigned WAIT_CYC     = TICKS_PER_MS * WAIT_MS;

    pbs_state_e state;
    logic       wait_done;
    logic       timer_start;

    // The timer starts on the cycle that switches slot power on.
    assign timer_start = (state == ST_PWR_ON);

    pbs_step_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .shutdown_i  (shutdown_i),
        .wait_done_i (wait_done),
        .phy_done_i  (phy_init_done_i),
        .state_o     (state)
    );

    pbs_ms_timer #(
        .CLK_HZ  (CLK_HZ),
        .WAIT_MS (WAIT_MS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (timer_start),
        .expired_o (wait_done)
    );

    pbs_out_regs #(
        .DEV_TYPE_W  (DEV_TYPE_W),
        .DEV_TYPE_RC (DEV_TYPE_RC)
    ) u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .state_i        (state),
        .perst_pin_n_o  (perst_pin_n_o),
        .ctrl_perst_n_o (ctrl_perst_n_o),
        .slot_pwr_en_o  (slot_pwr_en_o),
        .aux_clk_en_o   (aux_clk_en_o),
        .hold_phy_rst_o (hold_phy_rst_o),
        .pwrup_rst_n_o  (pwrup_rst_n_o),
        .dev_type_o     (dev_type_o),
        .phy_kick_o     (phy_init_start_o),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

endmodule

// File: rtl/pbs_checker.sv
// Property checker for pcie_bringup_seq, attached by bind.
// Assumes: only port-level signals are observed; the settling window is
// measured with a saturating counter instead of a long $past.
module pbs_checker #(
    parameter int unsigned WAIT_CYC   = 100,
    parameter int unsigned DEV_TYPE_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  perst_pin_n_o,
    input logic                  ctrl_perst_n_o,
    input logic                  slot_pwr_en_o,
    input logic                  aux_clk_en_o,
    input logic                  hold_phy_rst_o,
    input logic                  pwrup_rst_n_o,
    input logic [DEV_TYPE_W-1:0] dev_type_o,
    input logic                  phy_init_start_o,
    input logic                  busy_o,
    input logic                  done_o
);
    localparam int unsigned CW = $clog2(WAIT_CYC + 1) + 1;

    logic [CW-1:0] held_cnt;

    // Counts cycles with slot power on and the controller reset held.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_perst_n_o)                          held_cnt <= '0;
        else if (slot_pwr_en_o && held_cnt != CW'(WAIT_CYC))   held_cnt <= held_cnt + 1'b1;
    end

    AST_RESET_SAFE: assert property (@(posedge clk)
        !rst_n |=> (!perst_pin_n_o && !ctrl_perst_n_o && !slot_pwr_en_o && !busy_o && !done_o)); // R1

    AST_CTRL_FALL_AFTER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_perst_n_o) |-> !perst_pin_n_o); // R2

    AST_POWER_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_pwr_en_o) |-> (!perst_pin_n_o && !ctrl_perst_n_o)); // R3

    AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_perst_n_o) |-> (held_cnt >= CW'(WAIT_CYC))); // R4

    AST_PIN_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_pin_n_o) |-> (ctrl_perst_n_o && $past(ctrl_perst_n_o))); // R5

    AST_HOLD_NEEDS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_phy_rst_o) |-> aux_clk_en_o); // R6

    AST_KICK_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        phy_init_start_o |-> (hold_phy_rst_o && pwrup_rst_n_o)); // R7

    AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        phy_init_start_o |=> !phy_init_start_o); // R7

    AST_HOLD_DROP_CLOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_phy_rst_o) |-> !aux_clk_en_o); // R8

    AST_DEVTYPE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_type_o) |-> (!hold_phy_rst_o && aux_clk_en_o && done_o)); // R8

    AST_BUSY_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R12

endmodule

bind pcie_bringup_seq pbs_checker #(
    .WAIT_CYC   (WAIT_CYC),
    .DEV_TYPE_W (DEV_TYPE_W)
) u_pbs_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .perst_pin_n_o    (perst_pin_n_o),
    .ctrl_perst_n_o   (ctrl_perst_n_o),
    .slot_pwr_en_o    (slot_pwr_en_o),
    .aux_clk_en_o     (aux_clk_en_o),
    .hold_phy_rst_o   (hold_phy_rst_o),
    .pwrup_rst_n_o    (pwrup_rst_n_o),
    .dev_type_o       (dev_type_o),
    .phy_init_start_o (phy_init_start_o),
    .busy_o           (busy_o),
    .done_o           (done_o)
);

// File: tb/pcie_bringup_seq_bench.sv
// Scoreboard bench: driver tasks queue expected output snapshots with the
// allowed cycle gap since the previous change; a monitor compares every
// observed change against the head of the queue.
module pcie_bringup_seq_bench;
    localparam int unsigned CLK_HZ  = 10_000;
    localparam int unsigned WAIT_MS = 100;
    localparam int          N       = (CLK_HZ / 1000) * WAIT_MS;
    localparam int          BIG     = 32'h7fff_ffff;

    typedef struct packed {
        logic       pin;
        logic       ctrl;
        logic       slot;
        logic       aux;
        logic       hold;
        logic       pwrup;
        logic [3:0] dev;
        logic       kick;
        logic       busy;
        logic       done;
    } snap_t;

    typedef struct {
        snap_t vec;
        int    gmin;
        int    gmax;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic shutdown_i = 1'b0;
    logic phy_init_done_i = 1'b0;
    logic perst_pin_n_o, ctrl_perst_n_o, slot_pwr_en_o, aux_clk_en_o;
    logic hold_phy_rst_o, pwrup_rst_n_o, phy_init_start_o, busy_o, done_o;
    logic [3:0] dev_type_o;

    int    compared = 0;
    int    mismatched = 0;
    bit    armed = 1'b0;
    bit    finished = 1'b0;
    item_t expq[$];
    snap_t exp_s;

    always #5 clk = ~clk;

    pcie_bringup_seq #(
        .CLK_HZ      (CLK_HZ),
        .WAIT_MS     (WAIT_MS),
        .DEV_TYPE_W  (4),
        .DEV_TYPE_RC (4)
    ) u_pcie_bringup_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .shutdown_i       (shutdown_i),
        .phy_init_done_i  (phy_init_done_i),
        .perst_pin_n_o    (perst_pin_n_o),
        .ctrl_perst_n_o   (ctrl_perst_n_o),
        .slot_pwr_en_o    (slot_pwr_en_o),
        .aux_clk_en_o     (aux_clk_en_o),
        .hold_phy_rst_o   (hold_phy_rst_o),
        .pwrup_rst_n_o    (pwrup_rst_n_o),
        .dev_type_o       (dev_type_o),
        .phy_init_start_o (phy_init_start_o),
        .busy_o           (busy_o),
        .done_o           (done_o)
    );

    function automatic snap_t sample();
        snap_t s;
        s.pin   = perst_pin_n_o;
        s.ctrl  = ctrl_perst_n_o;
        s.slot  = slot_pwr_en_o;
        s.aux   = aux_clk_en_o;
        s.hold  = hold_phy_rst_o;
        s.pwrup = pwrup_rst_n_o;
        s.dev   = dev_type_o;
        s.kick  = phy_init_start_o;
        s.busy  = busy_o;
        s.done  = done_o;
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Queue the current expected snapshot with its allowed gap.
    task automatic push(input string tag, input int gmin, input int gmax);
        item_t it;
        it.vec  = exp_s;
        it.gmin = gmin;
        it.gmax = gmax;
        it.tag  = tag;
        expq.push_back(it);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1; cycles(1); start_i = 1'b0;
    endtask

    // Answer the PHY kick after a short delay.
    task automatic serve_phy();
        while (!phy_init_start_o) cycles(1);
        cycles(3);
        phy_init_done_i = 1'b1; cycles(1); phy_init_done_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) cycles(1);
        cycles(2);
    endtask

    // Monitor: every change of the output snapshot is one compared item.
    initial begin : monitor
        snap_t last;
        int    cyc = 0;
        int    last_cyc = 0;
        while (!armed) @(negedge clk);
        last = sample();
        forever begin
            snap_t cur;
            @(negedge clk);
            cyc++;
            cur = sample();
            if (cur !== last) begin
                compared++;
                if (expq.size() == 0) begin
                    mismatched++;
                    $display("FAIL unexpected change (R9/R11 quiet): actual %h expected %h", cur, last);
                end else begin
                    item_t it;
                    int gap;
                    it  = expq.pop_front();
                    gap = cyc - last_cyc;
                    if (cur !== it.vec || gap < it.gmin || gap > it.gmax) begin
                        mismatched++;
                        $display("FAIL %s: actual %h gap %0d expected %h gap %0d..%0d",
                                 it.tag, cur, gap, it.vec, it.gmin, it.gmax);
                    end
                end
                last     = cur;
                last_cyc = cyc;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : driver
        cycles(4);
        // R1: outputs during reset and right after release
        check("R1 during reset", 32'(sample()), 32'h0);
        rst_n = 1'b1;
        cycles(2);
        check("R1 after reset", 32'(sample()), 32'h0);
        exp_s = '0;
        armed = 1'b1;
        cycles(1);

        // First bring-up from idle, with a stray start inside the wait.
        exp_s.busy = 1'b1;                    push("R12 busy on start", 1, BIG);
        exp_s.slot = 1'b1;                    push("R3 power on", 3, 3);
        exp_s.ctrl = 1'b1;                    push("R4 ctrl release", N, N + 8);
        exp_s.pin  = 1'b1;                    push("R5 pin release", 1, 1);
        exp_s.aux  = 1'b1;                    push("R6 aux on", 1, 1);
        exp_s.hold = 1'b1;                    push("R6 hold set", 1, 1);
        exp_s.pwrup = 1'b1; exp_s.kick = 1'b1; push("R7 pwrup and kick", 1, 1);
        exp_s.kick = 1'b0;                    push("R7 kick pulse", 1, 1);
        exp_s.aux  = 1'b0;                    push("R8 aux off", 1, 64);
        exp_s.hold = 1'b0;                    push("R8 hold clear", 1, 1);
        exp_s.aux  = 1'b1;                    push("R8 aux restore", 1, 1);
        exp_s.dev = 4'd4; exp_s.busy = 1'b0; exp_s.done = 1'b1; push("R8 devtype ready", 1, 1);
        pulse_start();
        cycles(300);
        pulse_start();                        // R9: ignored while busy
        serve_phy();
        wait_done();

        // Restart from ready: reset ordering is visible now (R2).
        exp_s.busy = 1'b1; exp_s.done = 1'b0; push("R12 restart clears done", 1, BIG);
        exp_s.pin  = 1'b0;                    push("R2 pin assert", 1, 1);
        exp_s.ctrl = 1'b0;                    push("R2 ctrl assert", 1, 1);
        exp_s.ctrl = 1'b1;                    push("R4 ctrl release restart", N + 1, N + 9);
        exp_s.pin  = 1'b1;                    push("R5 pin release restart", 1, 1);
        exp_s.hold = 1'b1;                    push("R6 hold set restart", 2, 2);
        exp_s.kick = 1'b1;                    push("R7 kick restart", 1, 1);
        exp_s.kick = 1'b0;                    push("R7 kick pulse restart", 1, 1);
        exp_s.aux  = 1'b0;                    push("R8 aux off restart", 1, 64);
        exp_s.hold = 1'b0;                    push("R8 hold clear restart", 1, 1);
        exp_s.aux  = 1'b1;                    push("R8 aux restore restart", 1, 1);
        exp_s.busy = 1'b0; exp_s.done = 1'b1; push("R8 ready restart", 1, 1);
        pulse_start();
        serve_phy();
        wait_done();

        // Shutdown from ready, with a same-cycle start (R10, R11).
        exp_s.busy = 1'b1; exp_s.done = 1'b0; push("R10 shutdown busy", 1, BIG);
        exp_s.pin  = 1'b0;                    push("R10 shutdown pin", 1, 1);
        exp_s.ctrl = 1'b0; exp_s.busy = 1'b0; push("R10 shutdown ctrl", 1, 1);
        start_i = 1'b1; shutdown_i = 1'b1;
        cycles(1);
        start_i = 1'b0; shutdown_i = 1'b0;
        cycles(N + 30);                       // R11: no release may follow
        check("R10 power kept", 32'(slot_pwr_en_o), 32'h1);
        check("R10 devtype kept", 32'(dev_type_o), 32'h4);

        // Start from idle, then abort during the settling wait (R11).
        exp_s.busy = 1'b1;                    push("R12 busy abort run", 1, BIG);
        exp_s.busy = 1'b0;                    push("R11 abort to idle", 1, BIG);
        pulse_start();
        cycles(100);
        shutdown_i = 1'b1; cycles(1); shutdown_i = 1'b0;
        cycles(N + 30);
        check("R11 ctrl held", 32'(ctrl_perst_n_o), 32'h0);
        check("R11 pin held", 32'(perst_pin_n_o), 32'h0);

        check("R12 scoreboard drained", 32'(expq.size()), 32'h0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule